// File: doc/BRIEF.md
# Configurable Binary Correlation Array

This block compares a stream of multi-bit samples against a stored pattern that holds one bit per tap. The pool of taps is fixed and built as several equal shift-register stages. A width selector routes the sample bits into the stages. At one-bit precision every stage joins a single long chain. At wider precision the stages split into shorter chains, one chain per sample bit. Wider samples therefore correlate over a shorter window. Each tap scores one when its stored sample bit equals its reference bit, unless the tap is masked. The unmasked matches are summed into a raw score.

A split input divides the pool into two halves, and each half correlates on its own. The lower half of the sample bus feeds the lower stages and the upper half feeds the upper stages, giving two scores. Reference and mask vectors come from a separate loader and are used as presented. Each stage's oldest sample bit is brought out on a pass-through bus so that downstream logic can follow the delayed stream.

Top module: `cbc_array`

## Requirements
- R1: While `rst` is high at a rising edge, all tap history, both scores and `dout` become zero.
- R2: With `width_sel`=0 (1-bit data) and `split_en`=0, `din[0]` enters stage 0 and each stage's oldest tap feeds the next stage, forming one 256-tap chain. Tap index is stage*32+position, and position 0 holds the newest bit. `score_a` counts the unmasked taps whose sample bit equals `ref_bits` at that index; `din[7:1]` has no effect.
- R3: `width_sel` codes 0,1,2,3 select 1,2,4,8-bit data. Sample bit c feeds a chain of 8/B stages that starts at stage c*8/B, giving 256/128/64/32 taps per bit.
- R4: A `mask_bits` bit of 1 removes that tap from every score. When all bits are 1, both scores are 0.
- R5: With `split_en`=1, stages 0-3 take `din[3:0]` and stages 4-7 take `din[7:4]`, each half using the R3 routing within its own four stages. Code 3 acts as code 2. `score_a` scores the lower half and `score_b` the upper half, each at most 128.
- R6: With `split_en`=0, `score_b` is 0.
- R7: `dout[s]` is the oldest sample bit held in stage s.
- R8: A sample captured at a rising edge first counts in the scores updated at the next rising edge. Those scores use the `ref_bits`, `mask_bits` and `split_en` present at that next edge.
- R9: A change of `width_sel` or `split_en` is used at the first edge that sees it, and it leaves the stored tap history in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Sample bus, bit 0 is the LSB |
| width_sel | input | 2 | Sample precision code: 0,1,2,3 = 1,2,4,8 bits |
| split_en | input | 1 | 1 = two independent half correlators |
| ref_bits | input | 256 | Active reference, one bit per tap |
| mask_bits | input | 256 | Active mask, 1 excludes the tap |
| dout | output | 8 | Oldest sample bit of each stage |
| score_a | output | 9 | Full score, or lower-half score when split |
| score_b | output | 9 | Upper-half score when split, else 0 |

## Verification
`dout` follows a sample one edge after it is captured, because it is taken straight from the tap flops. The scores lag one edge further, since they are registered from the tap state before the shift. The bench drives each stimulus on a falling edge and updates its model in the same step: it first records the expected scores from the model's pre-shift taps, then shifts the model. After exactly one rising edge it compares all outputs on the next falling edge. Directed steps after reset pin down the one-edge score lag, and configuration changes are made mid-stream without a reset so that preserved history shows in the scores.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  parameter int CBC_STAGES = 8;
  parameter int CBC_TAPS   = 32;

  typedef enum logic [1:0] {
    WID_1 = 2'd0,
    WID_2 = 2'd1,
    WID_4 = 2'd2,
    WID_8 = 2'd3
  } wid_e;
endpackage

// File: rtl/cbc_stage.sv
module cbc_stage #(
  parameter int NTAP = 32,
  localparam int CW  = $clog2(NTAP + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sin,
  input  logic [NTAP-1:0] ref_v,
  input  logic [NTAP-1:0] msk,
  output logic            sout,
  output logic [CW-1:0]   count
);
  logic [NTAP-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= {q[NTAP-2:0], sin};
  end

  assign sout = q[NTAP-1];

  always_comb begin
    count = '0;
    for (int i = 0; i < NTAP; i++)
      count = count + CW'(~(q[i] ^ ref_v[i]) & ~msk[i]);
  end

  // R2: the newest tap holds the bit presented at the previous edge
  a_r2_newest_tap: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (q[0] == $past(sin)));

  // R4: masked taps never add to the stage count
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= $countones(~msk));
endmodule

// File: rtl/cbc_route.sv
module cbc_route import cbc_pkg::*; #(
  parameter int NSTG = 8,
  localparam int LG  = $clog2(NSTG)
) (
  input  wid_e            wsel,
  input  logic            split_en,
  input  logic [NSTG-1:0] din,
  input  logic [NSTG-1:0] tails,
  output logic [NSTG-1:0] feed
);
  logic [NSTG-1:0] prev_tail;
  assign prev_tail = {tails[NSTG-2:0], 1'b0};

  always_comb begin
    int lg_reg;
    int lg_b;
    int lg_len;
    int base;
    int idx;
    lg_reg = split_en ? LG - 1 : LG;
    lg_b   = (int'(wsel) > lg_reg) ? lg_reg : int'(wsel);
    lg_len = lg_reg - lg_b;
    base   = 0;
    idx    = 0;
    feed   = '0;
    for (int s = 0; s < NSTG; s++) begin
      base = split_en ? ((s >> (LG - 1)) << (LG - 1)) : 0;
      idx  = base + ((s - base) >> lg_len);
      if ((s & ((1 << lg_len) - 1)) == 0) feed[s] = din[idx[LG-1:0]];
      else                                feed[s] = prev_tail[s];
    end
  end
endmodule

// File: rtl/cbc_array.sv
module cbc_array import cbc_pkg::*; #(
  parameter int NSTG  = CBC_STAGES,
  parameter int NTAP  = CBC_TAPS,
  localparam int NBIT = NSTG * NTAP,
  localparam int HALF = NSTG / 2,
  localparam int CW   = $clog2(NTAP + 1),
  localparam int SW   = $clog2(NBIT + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSTG-1:0] din,
  input  logic [1:0]      width_sel,
  input  logic            split_en,
  input  logic [NBIT-1:0] ref_bits,
  input  logic [NBIT-1:0] mask_bits,
  output logic [NSTG-1:0] dout,
  output logic [SW-1:0]   score_a,
  output logic [SW-1:0]   score_b
);
  wid_e            wsel;
  logic [NSTG-1:0] feed;
  logic [NSTG-1:0] tails;
  logic [CW-1:0]   cnt [NSTG];
  logic [SW-1:0]   sum_lo;
  logic [SW-1:0]   sum_hi;

  assign wsel = wid_e'(width_sel);

  cbc_route #(.NSTG(NSTG)) u_route (
    .wsel     (wsel),
    .split_en (split_en),
    .din      (din),
    .tails    (tails),
    .feed     (feed)
  );

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    cbc_stage #(.NTAP(NTAP)) u_stg (
      .clk   (clk),
      .rst   (rst),
      .sin   (feed[g]),
      .ref_v (ref_bits[g*NTAP +: NTAP]),
      .msk   (mask_bits[g*NTAP +: NTAP]),
      .sout  (tails[g]),
      .count (cnt[g])
    );
  end

  always_comb begin
    sum_lo = '0;
    sum_hi = '0;
    for (int s = 0; s < NSTG; s++) begin
      if (s < HALF) sum_lo = sum_lo + SW'(cnt[s]);
      else          sum_hi = sum_hi + SW'(cnt[s]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      score_a <= '0;
      score_b <= '0;
    end else if (split_en) begin
      score_a <= sum_lo;
      score_b <= sum_hi;
    end else begin
      score_a <= sum_lo + sum_hi;
      score_b <= '0;
    end
  end

  assign dout = tails;

  // R6: single-correlator operation leaves the second score at zero
  a_r6_single_b_zero: assert property (@(posedge clk) disable iff (rst)
    !split_en |=> (score_b == '0));

  // R4: a fully masked array scores nothing
  a_r4_all_masked: assert property (@(posedge clk) disable iff (rst)
    (&mask_bits) |=> (score_a == '0 && score_b == '0));

  // R5: each half score stays within half the tap pool
  a_r5_half_bound: assert property (@(posedge clk) disable iff (rst)
    split_en |=> (int'(score_a) <= HALF * NTAP && int'(score_b) <= HALF * NTAP));

  // R3: stage 0 is fed from sample bit 0 in every mode
  a_r3_head_stage: assert property (@(posedge clk) disable iff (rst)
    feed[0] == din[0]);
endmodule

// File: tb/sim_cbc_array.sv
module sim_cbc_array;
  logic         clk = 1'b0;
  logic         rst;
  logic [7:0]   din;
  logic [1:0]   wsel;
  logic         split;
  logic [255:0] refv;
  logic [255:0] maskv;
  logic [7:0]   dout;
  logic [8:0]   score_a;
  logic [8:0]   score_b;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  bit m_tap [8][32];

  always #10 clk = ~clk;

  cbc_array u0 (
    .clk(clk), .rst(rst), .din(din), .width_sel(wsel), .split_en(split),
    .ref_bits(refv), .mask_bits(maskv), .dout(dout),
    .score_a(score_a), .score_b(score_b)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  // bench routing: which sample bit heads stage s, or 0-head means chained
  function automatic int src_bit(input int s, input int w, input bit sp, output bit head);
    int b, len;
    if (!sp) begin
      b = 1 << w; len = 8 / b;
      head = (s % len) == 0;
      return s / len;
    end else begin
      b = 1 << ((w > 2) ? 2 : w); len = 4 / b;
      head = (s % len) == 0;
      return 4 * (s / 4) + (s % 4) / len;
    end
  endfunction

  task automatic step(input logic [7:0] d, input int w, input bit sp, input string tag);
    int lo, hi, ea, eb, ed;
    bit nf [8];
    bit hd;
    int ix;
    din = d; wsel = 2'(w); split = sp;
    lo = 0; hi = 0;
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < 32; p++)
        if (!maskv[s*32+p] && (m_tap[s][p] == refv[s*32+p])) begin
          if (s < 4) lo++; else hi++;
        end
    ea = sp ? lo : lo + hi;
    eb = sp ? hi : 0;
    for (int s = 0; s < 8; s++) begin
      ix = src_bit(s, w, sp, hd);
      nf[s] = hd ? d[ix] : m_tap[(s > 0) ? s - 1 : 0][31];
    end
    for (int s = 0; s < 8; s++) begin
      for (int p = 31; p > 0; p--) m_tap[s][p] = m_tap[s][p-1];
      m_tap[s][0] = nf[s];
    end
    ed = 0;
    for (int s = 0; s < 8; s++) ed = ed | (int'(m_tap[s][31]) << s);
    @(posedge clk);
    @(negedge clk);
    chk($sformatf("%s score_a", tag), int'(score_a), ea);
    chk($sformatf("%s score_b", tag), int'(score_b), eb);
    chk($sformatf("%s dout R7", tag), int'(dout), ed);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; din = '0; wsel = '0; split = 1'b0;
    refv = '0; maskv = '0;
    for (int s = 0; s < 8; s++) for (int p = 0; p < 32; p++) m_tap[s][p] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset score_a", int'(score_a), 0);
    chk("R1 reset score_b", int'(score_b), 0);
    chk("R1 reset dout", int'(dout), 0);
    rst = 1'b0;

    // R8 directed: reference all ones, history zero
    refv = '1; maskv = '0;
    step(8'h01, 0, 1'b0, "R8 first");
    chk("R8 capture not yet scored", int'(score_a), 0);
    step(8'h00, 0, 1'b0, "R8 second");
    chk("R8 capture scored next edge", int'(score_a), 1);

    // R2: single chain, one-bit data, noise on upper bits
    refv = rnd256();
    for (int i = 0; i < 300; i++) step(8'($urandom), 0, 1'b0, "R2");

    // R3: wider precisions
    for (int w = 1; w < 4; w++) begin
      refv = rnd256();
      for (int i = 0; i < 80; i++) step(8'($urandom), w, 1'b0, "R3");
    end

    // R4: random masks, then everything masked
    for (int i = 0; i < 100; i++) begin
      if (i % 10 == 0) begin refv = rnd256(); maskv = rnd256(); end
      step(8'($urandom), int'($urandom_range(0, 3)), 1'b0, "R4");
    end
    maskv = '1;
    step(8'hFF, 0, 1'b0, "R4 all masked a");
    step(8'h00, 0, 1'b0, "R4 all masked b");
    chk("R4 fully masked score", int'(score_a), 0);
    maskv = '0;

    // R5/R6: split operation including code 3
    for (int i = 0; i < 160; i++) begin
      if (i % 40 == 0) refv = rnd256();
      step(8'($urandom), i / 40, 1'b1, "R5");
    end
    step(8'($urandom), 1, 1'b0, "R6");

    // R9: configuration changes mid-stream without reset
    for (int i = 0; i < 200; i++) begin
      if (i % 20 == 0) maskv = (i % 40 == 0) ? '0 : rnd256();
      step(8'($urandom), (i / 13) % 4, bit'((i / 17) % 2), "R9");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule